// File: doc/BRIEF.md
# Sequence-Count Lane Deskew

Three frame-aligned lanes together carry one wide word. Every frame has a 5-bit sequence count, and the sending side writes the same count into the matching frame of every lane. Each lane can arrive with a different delay. This block takes each lane's frames, with a per-lane valid and lock flag, into a small FIFO. It reads the count at the head of every FIFO and holds back the lanes that run ahead. It then releases three frames with the same count on one clock, so the output word matches the sent word bit for bit.

Sync acquisition and descrambling are done upstream, one lane at a time. The block does not rely on a common marker or on a fixed latency. The only alignment information it uses is the count inside each frame. Once aligned, it keeps watching the counts and the lock flags. On any inconsistency it drops back to searching.

Top module: `seq_deskew`

## Requirements
- R1: While reset is held, and after it is released, `valid_o`, `aligned_o` and `skew_ovf_o` are 0 and every output frame is all zeros.
- R2: The count of a frame sits in bits [15:11] of that frame. A lane's frame is written into its FIFO only when that lane's `valid_i` and `lock_i` are both 1. Each FIFO holds 4 frames.
- R3: A set of three frames with the same count is released on one clock. `valid_o` pulses for one cycle, and each lane's output carries that lane's frame unchanged. Frames written on edge N appear on the outputs after edge N+1 at the earliest.
- R4: While searching with all heads present, a lane's head is popped only if its count lags the leading head count. Lead and lag use modulo-32 order: count a is ahead of count b when (a-b) mod 32 is 1..15. The leader's head is held.
- R5: `aligned_o` goes to 1 on the edge that releases the first matched set. It stays 1 while later head sets match. `valid_o` is only ever 1 while `aligned_o` is 1.
- R6: While aligned, if all heads are present and their counts differ, the block empties every FIFO and clears `aligned_o` on that edge, then searches again.
- R7: If any `lock_i` is 0, the block empties every FIFO, clears `aligned_o` on that edge and accepts no frame on that edge.
- R8: `skew_ovf_o` is set when, during search with all heads present, some lane lags the leader by more than 2. It stays set until the next matched set is released. A lag of exactly 2 does not set it.
- R9: A write into a full FIFO whose head is not popped on the same edge empties every FIFO, and the search restarts.
- R10: When some head is empty, nothing is released and `aligned_o` is held. Between released sets, the output frames keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 3x160 | Frame of each lane |
| valid_i | input | 3 | Frame strobe of each lane |
| lock_i | input | 3 | Sync lock of each lane |
| frame_o | output | 3x160 | Aligned frames |
| valid_o | output | 1 | Aligned set released this cycle |
| aligned_o | output | 1 | Lanes are in step |
| skew_ovf_o | output | 1 | A lane lagged by more than 2 frames |

## Verification
Frames are pushed on the edge where they are driven. The heads are compared before the next edge, and a matched set is registered onto the outputs on that next edge. A frame driven before edge N is therefore visible just after edge N+1. Flushes caused by a lock drop, a head mismatch or a full FIFO take effect on the same edge at which the cause is present, so `aligned_o` and `valid_o` fall immediately after it. The bench drives inputs 1 ns after an edge and samples at that same point. Every check on a cycle's result is made after exactly the edge counted above, and each flush is proven at the ports by a fresh set of frames that could only match if the FIFOs were emptied.

// File: rtl/seq_deskew_pkg.sv
package seq_deskew_pkg;
  localparam int unsigned LANES_DEF   = 3;
  localparam int unsigned FRAME_W_DEF = 160;
  localparam int unsigned CNT_W_DEF   = 5;
  localparam int unsigned CNT_LSB_DEF = 11;
  localparam int unsigned DEPTH_DEF   = 4;
  localparam int unsigned LAG_MAX_DEF = 2;

  typedef enum logic {ST_SEARCH, ST_RUN} dsk_state_e;
endpackage

// File: rtl/deskew_lane_fifo.sv
module deskew_lane_fifo #(
  parameter int unsigned W     = 160,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/deskew_lead.sv
module deskew_lead #(
  parameter int unsigned LANES = 3,
  parameter int unsigned CNT_W = 5
) (
  input  logic [LANES-1:0][CNT_W-1:0] cnt_i,
  output logic [LANES-1:0][CNT_W-1:0] lag_o,
  output logic                        all_eq_o
);
  localparam logic [CNT_W-1:0] HALF = CNT_W'(1) << (CNT_W - 1);

  logic [CNT_W-1:0] lead;
  logic [CNT_W-1:0] diff;
  logic             found, is_lead;

  // leader: a head no other head is ahead of (modulo order)
  always_comb begin
    lead    = cnt_i[0];
    found   = 1'b0;
    is_lead = 1'b0;
    diff    = '0;
    for (int j = 0; j < LANES; j++) begin
      is_lead = 1'b1;
      for (int k = 0; k < LANES; k++) begin
        diff = cnt_i[j] - cnt_i[k];
        if (diff >= HALF) is_lead = 1'b0;
      end
      if (is_lead && !found) begin
        lead  = cnt_i[j];
        found = 1'b1;
      end
    end
  end

  always_comb begin
    all_eq_o = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      lag_o[k] = lead - cnt_i[k];
      if (lag_o[k] != '0) all_eq_o = 1'b0;
    end
  end
endmodule

// File: rtl/deskew_ctrl.sv
module deskew_ctrl
  import seq_deskew_pkg::*;
#(
  parameter int unsigned LANES   = 3,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned LAG_MAX = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [LANES-1:0]            lock_i,
  input  logic [LANES-1:0]            empty_i,
  input  logic [LANES-1:0][CNT_W-1:0] lag_i,
  input  logic                        all_eq_i,
  input  logic                        ovf_i,
  output logic [LANES-1:0]            pop_o,
  output logic                        flush_o,
  output logic                        load_o,
  output logic                        aligned_o,
  output logic                        skew_o
);
  dsk_state_e state_q, state_d;
  logic all_lock, all_head, far, load_req, flush_req, skew_q;

  assign all_lock = &lock_i;
  assign all_head = ~|empty_i;

  always_comb begin
    far = 1'b0;
    for (int k = 0; k < LANES; k++)
      if (lag_i[k] > CNT_W'(LAG_MAX)) far = 1'b1;
  end

  // pop / release decisions; independent of overflow
  always_comb begin
    pop_o     = '0;
    load_req  = 1'b0;
    flush_req = 1'b0;
    if (!all_lock) begin
      flush_req = 1'b1;
    end else if (all_head) begin
      if (all_eq_i) begin
        pop_o    = '1;
        load_req = 1'b1;
      end else if (state_q == ST_RUN) begin
        flush_req = 1'b1;
      end else begin
        for (int k = 0; k < LANES; k++) pop_o[k] = |lag_i[k];
      end
    end
  end

  assign flush_o = flush_req | ovf_i;
  assign load_o  = load_req & ~flush_o;

  always_comb begin
    state_d = state_q;
    if (flush_o)     state_d = ST_SEARCH;
    else if (load_o) state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_SEARCH;
      skew_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o)
        skew_q <= 1'b0;
      else if (state_q == ST_SEARCH && all_lock && all_head && !all_eq_i && far)
        skew_q <= 1'b1;
    end
  end

  assign aligned_o = (state_q == ST_RUN);
  assign skew_o    = skew_q;
endmodule

// File: rtl/seq_deskew.sv
module seq_deskew
  import seq_deskew_pkg::*;
#(
  parameter int unsigned LANES   = LANES_DEF,
  parameter int unsigned FRAME_W = FRAME_W_DEF,
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned CNT_LSB = CNT_LSB_DEF,
  parameter int unsigned DEPTH   = DEPTH_DEF,
  parameter int unsigned LAG_MAX = LAG_MAX_DEF
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [LANES-1:0][FRAME_W-1:0] frame_i,
  input  logic [LANES-1:0]              valid_i,
  input  logic [LANES-1:0]              lock_i,
  output logic [LANES-1:0][FRAME_W-1:0] frame_o,
  output logic                          valid_o,
  output logic                          aligned_o,
  output logic                          skew_ovf_o
);
  logic [LANES-1:0][FRAME_W-1:0] head;
  logic [LANES-1:0][CNT_W-1:0]   head_cnt, lag;
  logic [LANES-1:0] empty, full, pop, push_raw, push, ovf;
  logic all_eq, flush, load;

  assign push_raw = valid_i & lock_i;
  assign ovf      = push_raw & full & ~pop;
  assign push     = push_raw & ~{LANES{flush}};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    deskew_lane_fifo #(.W(FRAME_W), .DEPTH(DEPTH)) u_fifo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .flush_i(flush),
      .push_i (push[k]),
      .data_i (frame_i[k]),
      .pop_i  (pop[k]),
      .data_o (head[k]),
      .empty_o(empty[k]),
      .full_o (full[k])
    );
    assign head_cnt[k] = head[k][CNT_LSB +: CNT_W];
  end

  deskew_lead #(.LANES(LANES), .CNT_W(CNT_W)) u_lead (
    .cnt_i   (head_cnt),
    .lag_o   (lag),
    .all_eq_o(all_eq)
  );

  deskew_ctrl #(.LANES(LANES), .CNT_W(CNT_W), .LAG_MAX(LAG_MAX)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lock_i   (lock_i),
    .empty_i  (empty),
    .lag_i    (lag),
    .all_eq_i (all_eq),
    .ovf_i    (|ovf),
    .pop_o    (pop),
    .flush_o  (flush),
    .load_o   (load),
    .aligned_o(aligned_o),
    .skew_o   (skew_ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= load;
      if (load) frame_o <= head;
    end
  end
endmodule

// File: rtl/seq_deskew_chk.sv
module seq_deskew_chk #(
  parameter int unsigned LANES   = 3,
  parameter int unsigned FRAME_W = 160,
  parameter int unsigned CNT_W   = 5,
  parameter int unsigned CNT_LSB = 11
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [LANES-1:0]              lock_i,
  input logic [LANES-1:0][FRAME_W-1:0] frame_o,
  input logic                          valid_o,
  input logic                          aligned_o,
  input logic                          skew_ovf_o
);
  for (genvar k = 1; k < LANES; k++) begin : g_eq
    AST_OUT_CNT_EQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> frame_o[k][CNT_LSB +: CNT_W] == frame_o[0][CNT_LSB +: CNT_W]); // R3
  end

  AST_VALID_IN_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> aligned_o); // R5

  AST_ALIGN_WITH_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> valid_o); // R5

  AST_LOCK_LOSS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aligned_o && !(&lock_i) |=> !aligned_o && !valid_o); // R7

  AST_SKEW_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> !skew_ovf_o); // R8

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(frame_o)); // R10
endmodule

bind seq_deskew seq_deskew_chk #(
  .LANES(LANES), .FRAME_W(FRAME_W), .CNT_W(CNT_W), .CNT_LSB(CNT_LSB)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .lock_i    (lock_i),
  .frame_o   (frame_o),
  .valid_o   (valid_o),
  .aligned_o (aligned_o),
  .skew_ovf_o(skew_ovf_o)
);

// File: tb/sim_seq_deskew.sv
`timescale 1ns/1ps
module sim_seq_deskew;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0][159:0] frame_i;
  logic [2:0] valid_i, lock_i;
  logic [2:0][159:0] frame_o;
  logic valid_o, aligned_o, skew_ovf_o;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  seq_deskew u0 (
    .clk_i(clk), .rst_ni(rst_ni), .frame_i(frame_i), .valid_i(valid_i),
    .lock_i(lock_i), .frame_o(frame_o), .valid_o(valid_o),
    .aligned_o(aligned_o), .skew_ovf_o(skew_ovf_o)
  );

  typedef struct packed {
    logic [2:0] v;
    logic [4:0] c0, c1, c2;
    logic       ev;
    logic [4:0] ec;
    logic       ea;
  } vec_t;

  // lanes start one cycle apart, then gaps
  localparam vec_t TAB [10] = '{
    '{3'b001, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0},
    '{3'b011, 5'd1, 5'd0, 5'd0, 1'b0, 5'd0, 1'b0},
    '{3'b111, 5'd2, 5'd1, 5'd0, 1'b0, 5'd0, 1'b0},
    '{3'b111, 5'd3, 5'd2, 5'd1, 1'b1, 5'd0, 1'b1},
    '{3'b111, 5'd4, 5'd3, 5'd2, 1'b1, 5'd1, 1'b1},
    '{3'b111, 5'd5, 5'd4, 5'd3, 1'b1, 5'd2, 1'b1},
    '{3'b000, 5'd0, 5'd0, 5'd0, 1'b1, 5'd3, 1'b1},
    '{3'b000, 5'd0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1},
    '{3'b111, 5'd6, 5'd5, 5'd4, 1'b0, 5'd0, 1'b1},
    '{3'b111, 5'd7, 5'd6, 5'd5, 1'b1, 5'd4, 1'b1}
  };

  function automatic logic [159:0] mk(input int lane, input logic [4:0] c);
    logic [159:0] f;
    for (int b = 0; b < 20; b++) f[b*8 +: 8] = {2'(lane), c, 1'b1};
    f[15:11] = c;
    return f;
  endfunction

  task automatic step(input logic [2:0] v, input logic [4:0] c0, input logic [4:0] c1,
                      input logic [4:0] c2, input logic [2:0] lk);
    valid_i = v;
    lock_i  = lk;
    frame_i[0] = mk(0, c0);
    frame_i[1] = mk(1, c1);
    frame_i[2] = mk(2, c2);
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic ev, input logic [4:0] ec, input logic ea);
    logic ok;
    total++;
    ok = (valid_o === ev) && (aligned_o === ea);
    if (ev)
      for (int k = 0; k < 3; k++) if (frame_o[k] !== mk(k, ec)) ok = 1'b0;
    if (!ok) begin
      bad++;
      $display("FAIL %s: valid=%0b aligned=%0b cnt0=%0d exp valid=%0b aligned=%0b cnt=%0d",
               req, valid_o, aligned_o, frame_o[0][15:11], ev, ea, ec);
    end
  endtask

  task automatic chk_skew(input string req, input logic exp);
    total++;
    if (skew_ovf_o !== exp) begin
      bad++;
      $display("FAIL %s: skew_ovf=%0b exp=%0b", req, skew_ovf_o, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni  = 1'b0;
    valid_i = '0;
    lock_i  = '1;
    frame_i = '0;
    repeat (2) @(posedge clk);
    #1;
    rst_ni = 1'b1;
  endtask

  initial begin
    #(5.0 * 20000);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    total++;
    if (valid_o !== 1'b0 || aligned_o !== 1'b0 || skew_ovf_o !== 1'b0 || frame_o !== '0) begin
      bad++;
      $display("FAIL R1: valid=%0b aligned=%0b skew=%0b exp all zero", valid_o, aligned_o, skew_ovf_o);
    end

    // R3 R5 R10 table walk
    foreach (TAB[i]) begin
      step(TAB[i].v, TAB[i].c0, TAB[i].c1, TAB[i].c2, 3'b111);
      chk("R3_R10_table", TAB[i].ev, TAB[i].ec, TAB[i].ea);
    end
    chk_skew("R8_no_lag", 1'b0);

    // R4 laggards popped across count wrap; R8 lag 2 does not flag
    do_reset();
    step(3'b111, 5'd1, 5'd31, 5'd0, 3'b111); chk("R4", 1'b0, 5'd0, 1'b0);
    step(3'b111, 5'd2, 5'd0, 5'd1, 3'b111); chk("R4", 1'b0, 5'd0, 1'b0);
    chk_skew("R8_lag2", 1'b0);
    step(3'b111, 5'd3, 5'd1, 5'd2, 3'b111); chk("R4", 1'b0, 5'd0, 1'b0);
    step(3'b111, 5'd4, 5'd2, 5'd3, 3'b111); chk("R4_R5", 1'b1, 5'd1, 1'b1);
    step(3'b111, 5'd5, 5'd3, 5'd4, 3'b111); chk("R4", 1'b1, 5'd2, 1'b1);

    // R8 lag 4 flags; R9 full FIFO push flushes
    do_reset();
    step(3'b111, 5'd9, 5'd5, 5'd9, 3'b111);
    step(3'b111, 5'd10, 5'd6, 5'd10, 3'b111);
    chk_skew("R8_set", 1'b1);
    step(3'b111, 5'd11, 5'd7, 5'd11, 3'b111);
    step(3'b111, 5'd12, 5'd8, 5'd12, 3'b111); chk("R9_pre", 1'b0, 5'd0, 1'b0);
    step(3'b111, 5'd13, 5'd9, 5'd13, 3'b111); chk("R9_flush", 1'b0, 5'd0, 1'b0);
    chk_skew("R8_hold", 1'b1);
    step(3'b111, 5'd20, 5'd20, 5'd20, 3'b111);
    step(3'b000, 5'd0, 5'd0, 5'd0, 3'b111); chk("R9_restart", 1'b1, 5'd20, 1'b1);
    chk_skew("R8_clear", 1'b0);

    // R6 head mismatch while aligned
    do_reset();
    step(3'b111, 5'd0, 5'd0, 5'd0, 3'b111); chk("R3_lat", 1'b0, 5'd0, 1'b0);
    step(3'b111, 5'd1, 5'd1, 5'd1, 3'b111); chk("R3_lat", 1'b1, 5'd0, 1'b1);
    step(3'b111, 5'd2, 5'd2, 5'd9, 3'b111); chk("R6", 1'b1, 5'd1, 1'b1);
    step(3'b111, 5'd3, 5'd3, 5'd3, 3'b111); chk("R6_drop", 1'b0, 5'd0, 1'b0);
    step(3'b111, 5'd4, 5'd4, 5'd4, 3'b111); chk("R6", 1'b0, 5'd0, 1'b0);
    step(3'b000, 5'd0, 5'd0, 5'd0, 3'b111); chk("R6_realign", 1'b1, 5'd4, 1'b1);

    // R7 lock loss; R2 unlocked frame not taken
    do_reset();
    step(3'b111, 5'd0, 5'd0, 5'd0, 3'b111);
    step(3'b111, 5'd1, 5'd1, 5'd1, 3'b111); chk("R7_pre", 1'b1, 5'd0, 1'b1);
    step(3'b111, 5'd2, 5'd2, 5'd2, 3'b111); chk("R7_pre", 1'b1, 5'd1, 1'b1);
    step(3'b111, 5'd3, 5'd3, 5'd3, 3'b101); chk("R7", 1'b0, 5'd0, 1'b0);
    step(3'b111, 5'd4, 5'd4, 5'd4, 3'b111); chk("R2_R7", 1'b0, 5'd0, 1'b0);
    step(3'b000, 5'd0, 5'd0, 5'd0, 3'b111); chk("R2_R7", 1'b1, 5'd4, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule